// File: doc/BRIEF.md
# Phase-Checked Bus Block-Move Engine

This block executes a single block-move command on a parallel, byte-wide peripheral bus that paces every byte with a REQ/ACK handshake. A command carries a 3-bit bus phase code and a 24-bit byte count. The engine can act as either side of the bus. As initiator, it first waits for the bus phase lines to settle. It then compares them with the commanded phase, and moves bytes only while they agree. As target, it drives the phase lines itself and runs the REQ side of the handshake.

Bytes come from a simple memory-side source port or go to a sink port, depending on the phase's direction bit and the engine's role. A working counter starts at the command's byte count and steps down on each byte. Its value is visible at all times. Two message phases get special treatment at the end of a transfer. When the last outgoing message byte is acknowledged, ATN is released. When the last incoming message byte has been taken, ACK stays asserted until a separate clear command arrives.

Top module: `bus_xfer_engine`

## Requirements
- R1: The phase code is {MSG, C_D, I_O}: 000 data-out, 001 data-in, 010 command, 011 status, 100/101 reserved, 110 message-out, 111 message-in. I_O=1 means bytes travel toward the initiator. As initiator with I_O=0, source bytes go out on `bus_data_out`. As initiator with I_O=1, `bus_data_in` bytes go to the sink. In target role the direction is the opposite.
- R2: A start loads `remaining` with the command count. `remaining` drops by exactly one per byte moved and reads 0 after a complete transfer, which also sets `done`.
- R3: As initiator, if the settled bus phase differs from the commanded phase at start, `irq` rises with `irq_cause`=01. No ACK is given, no source byte is taken, and `remaining` keeps the command count.
- R4: In target role, `bus_phase_oe` is 1 and `bus_phase_out` equals the commanded phase for the whole transfer. Each byte raises `bus_req_out`, waits for `bus_ack_in`, then drops REQ and waits for ACK to fall.
- R5: In a message-out transfer as initiator, ATN (raised by `set_atn`) stays asserted through earlier bytes. It falls in the same cycle that ACK rises for the final byte.
- R6: After the last byte of a message-in transfer as initiator, ACK stays high and `ack_held`=1. A `clear_ack` pulse drops both.
- R7: A start with count 0 sets `done` on the next cycle with no REQ or ACK activity and no source byte taken.
- R8: The phase is compared only after it has held one value for at least two clocks past synchronization. A phase glitch lasting a single clock causes no mismatch.
- R9: If the phase changes between bytes of an initiator transfer, the engine stops. It raises `irq` with cause 01, leaves `done` low and keeps the untransferred count in `remaining`.
- R10: As initiator, ACK rises only after REQ has been seen high. ACK stays high while REQ is high and falls after REQ is seen low, except for the held message-in case.
- R11: A start while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block move with the command fields |
| target_mode | input | 1 | 1 = act as target, 0 = initiator |
| instr_phase | input | 3 | Commanded phase code |
| instr_count | input | 24 | Commanded byte count |
| set_atn | input | 1 | Assert ATN |
| clear_ack | input | 1 | Release a held ACK |
| bus_phase_in | input | 3 | Phase lines seen on the bus |
| bus_phase_out | output | 3 | Phase lines driven in target role |
| bus_phase_oe | output | 1 | Phase line drive enable |
| bus_req_in | input | 1 | REQ from the bus (initiator role) |
| bus_req_out | output | 1 | REQ driven (target role) |
| bus_ack_in | input | 1 | ACK from the bus (target role) |
| bus_ack_out | output | 1 | ACK driven (initiator role) |
| bus_atn_out | output | 1 | ATN driven |
| bus_data_in | input | 8 | Data byte from the bus |
| bus_data_out | output | 8 | Data byte to the bus |
| bus_data_oe | output | 1 | Data drive enable |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_take | output | 1 | Source byte consumed this cycle |
| snk_valid | output | 1 | Sink byte offered |
| snk_data | output | 8 | Sink byte |
| snk_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| irq | output | 1 | Interrupt pending |
| irq_cause | output | 2 | Interrupt cause, 01 = phase mismatch |
| remaining | output | 24 | Working byte counter |
| ack_held | output | 1 | ACK kept asserted after message-in |

## Verification
The hardest case to reach from the ports is a phase change that lands between two bytes of a running initiator transfer. The mirror case is a one-clock phase glitch that has to be ignored. The bench plays the target side of the bus. In the first case, it finishes two bytes of a four-byte data-in move and lowers REQ. It then moves the phase lines to a different code and checks the interrupt and the remaining count. In the second case, it parks the engine waiting for REQ and flips the phase lines for exactly one clock before it lets the byte through.

// File: rtl/bxe_pkg.sv
package bxe_pkg;

  typedef enum logic [2:0] {
    PH_DOUT  = 3'b000,
    PH_DIN   = 3'b001,
    PH_CMD   = 3'b010,
    PH_STAT  = 3'b011,
    PH_RSV_O = 3'b100,
    PH_RSV_I = 3'b101,
    PH_MOUT  = 3'b110,
    PH_MIN   = 3'b111
  } bus_phase_e;

  localparam logic [1:0] CAUSE_NONE  = 2'b00;
  localparam logic [1:0] CAUSE_PHASE = 2'b01;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_IREQ,
    S_ISINK,
    S_IWNREQ,
    S_TREQ,
    S_TWACK,
    S_TSINK,
    S_TWNACK
  } xfer_state_e;

endpackage

// File: rtl/bxe_line_sync.sv
module bxe_line_sync #(
  parameter int PW         = 3,
  parameter int STABLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase_in,
  input  logic          req_in,
  input  logic          ack_in,
  output logic [PW-1:0] phase_q,
  output logic          phase_stable,
  output logic          req_q,
  output logic          ack_q
);
  localparam int CNTW = $clog2(STABLE_CYC + 1);

  logic [PW-1:0]   ph_m, ph_s;
  logic [1:0]      req_p, ack_p;
  logic [CNTW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_m    <= '0;
      ph_s    <= '0;
      phase_q <= '0;
      run     <= '0;
      req_p   <= '0;
      ack_p   <= '0;
    end else begin
      ph_m  <= phase_in;
      ph_s  <= ph_m;
      req_p <= {req_p[0], req_in};
      ack_p <= {ack_p[0], ack_in};
      if (ph_s != phase_q) begin
        phase_q <= ph_s;
        run     <= '0;
      end else if (run != CNTW'(STABLE_CYC)) begin
        run <= run + 1'b1;
      end
    end
  end

  assign phase_stable = (run == CNTW'(STABLE_CYC));
  assign req_q        = req_p[1];
  assign ack_q        = ack_p[1];

  // R8: a settled phase value has not moved in the last cycle
  assert_stable_hold_R8: assert property (@(posedge clk) disable iff (rst)
    phase_stable |-> (phase_q == $past(phase_q)));

endmodule

// File: rtl/bxe_byte_counter.sv
module bxe_byte_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] value,
  output logic          is_zero,
  output logic          is_last
);
  always_ff @(posedge clk) begin
    if (rst)                     value <= '0;
    else if (load)               value <= load_val;
    else if (dec && value != '0) value <= value - 1'b1;
  end

  assign is_zero = (value == '0);
  assign is_last = (value == CW'(1));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (value == $past(load_val)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !is_zero) |=> (value == $past(value) - 1'b1));

endmodule

// File: rtl/bxe_xfer_fsm.sv
module bxe_xfer_fsm
  import bxe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          target_mode,
  input  logic [2:0]    instr_phase,
  input  logic          start_zero,
  input  logic          set_atn,
  input  logic          clear_ack,
  input  logic [2:0]    phase_q,
  input  logic          phase_stable,
  input  logic          req_q,
  input  logic          ack_q,
  input  logic [DW-1:0] bus_data_in,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  input  logic          snk_ready,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  output logic          cnt_load,
  output logic          cnt_dec,
  output logic [2:0]    ph_out,
  output logic          ph_oe,
  output logic          req_o,
  output logic          ack_o,
  output logic          atn_o,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic          src_take,
  output logic          snk_valid,
  output logic [DW-1:0] snk_data,
  output logic          busy,
  output logic          done_o,
  output logic          irq_o,
  output logic [1:0]    cause_o,
  output logic          held
);
  xfer_state_e st;
  bus_phase_e  ph;
  logic        tgt;
  logic        out_dir;
  logic        mism;
  logic        i_go;

  // 1: bytes flow memory -> bus
  assign out_dir = tgt ? ph[0] : ~ph[0];
  assign mism    = phase_stable && (phase_q != ph);
  assign i_go    = phase_stable && !mism && req_q;
  assign busy    = (st != S_IDLE);

  always_comb begin
    cnt_load = (st == S_IDLE) && start;
    cnt_dec  = ((st == S_IREQ) && i_go && out_dir && src_valid) ||
               ((st == S_ISINK) && snk_ready) ||
               ((st == S_TWACK) && ack_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ph        <= PH_DOUT;
      tgt       <= 1'b0;
      ph_out    <= '0;
      ph_oe     <= 1'b0;
      req_o     <= 1'b0;
      ack_o     <= 1'b0;
      atn_o     <= 1'b0;
      d_out     <= '0;
      d_oe      <= 1'b0;
      src_take  <= 1'b0;
      snk_valid <= 1'b0;
      snk_data  <= '0;
      done_o    <= 1'b0;
      irq_o     <= 1'b0;
      cause_o   <= CAUSE_NONE;
      held      <= 1'b0;
    end else begin
      src_take <= 1'b0;
      if (set_atn) atn_o <= 1'b1;
      if (held && clear_ack) begin
        held  <= 1'b0;
        ack_o <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (start) begin
            ph      <= bus_phase_e'(instr_phase);
            tgt     <= target_mode;
            done_o  <= 1'b0;
            irq_o   <= 1'b0;
            cause_o <= CAUSE_NONE;
            if (start_zero) begin
              done_o <= 1'b1;
            end else if (target_mode) begin
              ph_oe  <= 1'b1;
              ph_out <= instr_phase;
              st     <= S_TREQ;
            end else begin
              st <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (phase_stable) begin
            if (mism) begin
              irq_o   <= 1'b1;
              cause_o <= CAUSE_PHASE;
              st      <= S_IDLE;
            end else begin
              st <= S_IREQ;
            end
          end
        end
        S_IREQ: begin
          if (mism) begin
            irq_o   <= 1'b1;
            cause_o <= CAUSE_PHASE;
            st      <= S_IDLE;
          end else if (i_go) begin
            if (out_dir) begin
              if (src_valid) begin
                d_out    <= src_data;
                d_oe     <= 1'b1;
                src_take <= 1'b1;
                ack_o    <= 1'b1;
                if (cnt_last && ph == PH_MOUT) atn_o <= 1'b0;
                st <= S_IWNREQ;
              end
            end else begin
              snk_data  <= bus_data_in;
              snk_valid <= 1'b1;
              st        <= S_ISINK;
            end
          end
        end
        S_ISINK: begin
          if (snk_ready) begin
            snk_valid <= 1'b0;
            ack_o     <= 1'b1;
            st        <= S_IWNREQ;
          end
        end
        S_IWNREQ: begin
          if (!req_q) begin
            d_oe <= 1'b0;
            if (cnt_zero) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
              if (ph == PH_MIN) held  <= 1'b1;
              else              ack_o <= 1'b0;
            end else begin
              ack_o <= 1'b0;
              st    <= S_IREQ;
            end
          end
        end
        S_TREQ: begin
          if (out_dir) begin
            if (src_valid) begin
              d_out    <= src_data;
              d_oe     <= 1'b1;
              src_take <= 1'b1;
              req_o    <= 1'b1;
              st       <= S_TWACK;
            end
          end else begin
            req_o <= 1'b1;
            st    <= S_TWACK;
          end
        end
        S_TWACK: begin
          if (ack_q) begin
            if (out_dir) begin
              req_o <= 1'b0;
              st    <= S_TWNACK;
            end else begin
              snk_data  <= bus_data_in;
              snk_valid <= 1'b1;
              st        <= S_TSINK;
            end
          end
        end
        S_TSINK: begin
          if (snk_ready) begin
            snk_valid <= 1'b0;
            req_o     <= 1'b0;
            st        <= S_TWNACK;
          end
        end
        S_TWNACK: begin
          if (!ack_q) begin
            d_oe <= 1'b0;
            if (cnt_zero) begin
              done_o <= 1'b1;
              ph_oe  <= 1'b0;
              st     <= S_IDLE;
            end else begin
              st <= S_TREQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mismatch_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (!src_take && !snk_valid && !req_o));

  assert_target_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (tgt && busy) |-> (ph_oe && ph_out == ph));

  assert_atn_drop_final_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(atn_o) |-> ack_o);

  assert_held_keeps_ack_R6: assert property (@(posedge clk) disable iff (rst)
    held |-> ack_o);

  assert_zero_no_handshake_R7: assert property (@(posedge clk) disable iff (rst)
    ((st == S_IDLE) && start && start_zero) |=> (done_o && !busy && !src_take));

  assert_ack_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(req_q));

  assert_ack_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> (!$past(req_q) || $past(held)));

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (ph == $past(ph) && tgt == $past(tgt)));

endmodule

// File: rtl/bus_xfer_engine.sv
module bus_xfer_engine #(
  parameter int DW         = 8,
  parameter int CW         = 24,
  parameter int STABLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          target_mode,
  input  logic [2:0]    instr_phase,
  input  logic [CW-1:0] instr_count,
  input  logic          set_atn,
  input  logic          clear_ack,
  input  logic [2:0]    bus_phase_in,
  output logic [2:0]    bus_phase_out,
  output logic          bus_phase_oe,
  input  logic          bus_req_in,
  output logic          bus_req_out,
  input  logic          bus_ack_in,
  output logic          bus_ack_out,
  output logic          bus_atn_out,
  input  logic [DW-1:0] bus_data_in,
  output logic [DW-1:0] bus_data_out,
  output logic          bus_data_oe,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_take,
  output logic          snk_valid,
  output logic [DW-1:0] snk_data,
  input  logic          snk_ready,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic [1:0]    irq_cause,
  output logic [CW-1:0] remaining,
  output logic          ack_held
);
  logic [2:0] phase_q;
  logic       phase_stable, req_q, ack_q;
  logic       cnt_load, cnt_dec, cnt_zero, cnt_last;

  bxe_line_sync #(.PW(3), .STABLE_CYC(STABLE_CYC)) u_sync (
    .clk(clk), .rst(rst),
    .phase_in(bus_phase_in), .req_in(bus_req_in), .ack_in(bus_ack_in),
    .phase_q(phase_q), .phase_stable(phase_stable),
    .req_q(req_q), .ack_q(ack_q)
  );

  bxe_byte_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst),
    .load(cnt_load), .load_val(instr_count), .dec(cnt_dec),
    .value(remaining), .is_zero(cnt_zero), .is_last(cnt_last)
  );

  bxe_xfer_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst),
    .start(start), .target_mode(target_mode), .instr_phase(instr_phase),
    .start_zero(instr_count == '0),
    .set_atn(set_atn), .clear_ack(clear_ack),
    .phase_q(phase_q), .phase_stable(phase_stable),
    .req_q(req_q), .ack_q(ack_q),
    .bus_data_in(bus_data_in),
    .src_valid(src_valid), .src_data(src_data), .snk_ready(snk_ready),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .cnt_load(cnt_load), .cnt_dec(cnt_dec),
    .ph_out(bus_phase_out), .ph_oe(bus_phase_oe),
    .req_o(bus_req_out), .ack_o(bus_ack_out), .atn_o(bus_atn_out),
    .d_out(bus_data_out), .d_oe(bus_data_oe),
    .src_take(src_take), .snk_valid(snk_valid), .snk_data(snk_data),
    .busy(busy), .done_o(done), .irq_o(irq), .cause_o(irq_cause),
    .held(ack_held)
  );

endmodule

// File: tb/sim_bus_xfer_engine.sv
module sim_bus_xfer_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 0, target_mode = 0, set_atn = 0, clear_ack = 0;
  logic [2:0]  instr_phase = 0;
  logic [23:0] instr_count = 0;
  logic [2:0]  bus_phase_in = 0;
  logic [2:0]  bus_phase_out;
  logic        bus_phase_oe, bus_req_out, bus_ack_out, bus_atn_out, bus_data_oe;
  logic        bus_req_in = 0, bus_ack_in = 0;
  logic [7:0]  bus_data_in = 0, bus_data_out;
  logic        src_valid = 1'b1, src_take, snk_valid, snk_ready = 1'b1;
  logic [7:0]  src_data, snk_data;
  logic        busy, done, irq, ack_held;
  logic [1:0]  irq_cause;
  logic [23:0] remaining;

  int n_chk = 0, n_bad = 0;
  int src_idx = 0, exp_src = 0, snk_n = 0;
  logic [7:0] snk_last = 0;

  always #10 clk = ~clk;

  bus_xfer_engine u0 (.*);

  assign src_data = 8'hA0 + src_idx[7:0];
  always @(posedge clk) begin
    if (rst) src_idx <= 0;
    else if (src_take) src_idx <= src_idx + 1;
    if (!rst && snk_valid && snk_ready) begin
      snk_n    <= snk_n + 1;
      snk_last <= snk_data;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(input logic lvl);
    int n = 0;
    while (bus_ack_out !== lvl && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) check(0, "R10 ack timeout", bus_ack_out, lvl);
  endtask

  task automatic wait_req(input logic lvl);
    int n = 0;
    while (bus_req_out !== lvl && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) check(0, "R4 req timeout", bus_req_out, lvl);
  endtask

  task automatic kick(input logic tg, input logic [2:0] ph, input logic [23:0] cnt);
    @(negedge clk);
    start = 1; target_mode = tg; instr_phase = ph; instr_count = cnt;
    @(negedge clk);
    start = 0;
  endtask

  // bench plays target; engine is initiator
  task automatic tgt_side_byte(input logic outb, input logic [7:0] val,
                               input logic chk_atn, input logic exp_atn, input logic hold);
    check(bus_ack_out == 1'b0, "R10 ack low before req", bus_ack_out, 0);
    bus_data_in = val;
    bus_req_in  = 1'b1;
    wait_ack(1'b1);
    if (outb) check(bus_data_out == val, "R1 initiator data out", bus_data_out, val);
    if (chk_atn) check(bus_atn_out == exp_atn, "R5 atn at ack", bus_atn_out, exp_atn);
    repeat (3) @(negedge clk);
    check(bus_ack_out == 1'b1, "R10 ack held while req high", bus_ack_out, 1);
    bus_req_in = 1'b0;
    if (hold) begin
      repeat (8) @(negedge clk);
      check(bus_ack_out == 1'b1 && ack_held == 1'b1, "R6 ack kept after msg-in",
            {bus_ack_out, ack_held}, 2'b11);
    end else begin
      wait_ack(1'b0);
    end
  endtask

  // bench plays initiator; engine is target
  task automatic ini_side_byte(input logic outb, input logic [7:0] val, input logic [2:0] ph);
    wait_req(1'b1);
    check(bus_phase_oe && bus_phase_out == ph, "R4 target drives phase", bus_phase_out, ph);
    if (outb) check(bus_data_out == val, "R1 target data out", bus_data_out, val);
    else bus_data_in = val;
    bus_ack_in = 1'b1;
    wait_req(1'b0);
    bus_ack_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // {target, phase, bus phase, expect mismatch, count}
  localparam logic [15:0] VEC [11] = '{
    {1'b0, 3'b000, 3'b000, 1'b0, 8'd3},
    {1'b0, 3'b001, 3'b001, 1'b0, 8'd2},
    {1'b0, 3'b010, 3'b010, 1'b0, 8'd4},
    {1'b0, 3'b011, 3'b011, 1'b0, 8'd1},
    {1'b0, 3'b110, 3'b110, 1'b0, 8'd3},
    {1'b0, 3'b111, 3'b111, 1'b0, 8'd2},
    {1'b0, 3'b000, 3'b001, 1'b1, 8'd5},
    {1'b0, 3'b111, 3'b011, 1'b1, 8'd1},
    {1'b1, 3'b001, 3'b000, 1'b0, 8'd3},
    {1'b1, 3'b000, 3'b000, 1'b0, 8'd2},
    {1'b1, 3'b011, 3'b000, 1'b0, 8'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!done && !irq && !busy && !bus_ack_out && !bus_atn_out && !bus_req_out && !bus_phase_oe
          && remaining == 0, "R2 reset state", {done, irq, busy, bus_ack_out}, 0);

    for (int v = 0; v < 11; v++) begin
      logic tg, mis, outb;
      logic [2:0] ph, bph;
      int cnt, src0, snk0;
      {tg, ph, bph, mis} = VEC[v][15:8];
      cnt  = int'(VEC[v][7:0]);
      outb = tg ? ph[0] : ~ph[0];
      bus_phase_in = bph;
      if (!tg && ph == 3'b110) begin
        @(negedge clk); set_atn = 1; @(negedge clk); set_atn = 0;
        @(negedge clk);
        check(bus_atn_out == 1'b1, "R5 atn raised", bus_atn_out, 1);
      end
      repeat (8) @(negedge clk);
      src0 = src_idx; snk0 = snk_n;
      kick(tg, ph, 24'(cnt));
      if (mis) begin
        repeat (12) @(negedge clk);
        check(irq && irq_cause == 2'b01, "R3 mismatch irq", {irq, irq_cause}, 3'b101);
        check(remaining == 24'(cnt) && !done, "R3 count untouched", remaining, cnt);
        check(src_idx == src0 && snk_n == snk0 && !bus_ack_out, "R3 no transfer",
              src_idx - src0, 0);
      end else begin
        for (int b = 0; b < cnt; b++) begin
          logic last;
          logic [7:0] val;
          last = (b == cnt - 1);
          val  = outb ? 8'hA0 + exp_src[7:0] : 8'h50 + 8'(b);
          if (outb) exp_src++;
          if (tg) ini_side_byte(outb, val, ph);
          else tgt_side_byte(outb, val, ph == 3'b110, !last, last && ph == 3'b111);
        end
        repeat (4) @(negedge clk);
        check(done && !irq && remaining == 0, "R2 transfer complete", remaining, 0);
        if (outb) check(src_idx - src0 == cnt, "R1 source bytes taken", src_idx - src0, cnt);
        else check(snk_n - snk0 == cnt && snk_last == 8'h50 + 8'(cnt - 1),
                   "R1 sink bytes", snk_last, 8'h50 + 8'(cnt - 1));
        if (tg) check(!bus_phase_oe, "R4 phase released", bus_phase_oe, 0);
        if (!tg && ph == 3'b111) begin
          clear_ack = 1; @(negedge clk); clear_ack = 0;
          @(negedge clk);
          check(!bus_ack_out && !ack_held, "R6 clear releases ack", bus_ack_out, 0);
        end
      end
    end

    // R7: zero count
    begin
      int s0;
      s0 = src_idx;
      kick(1'b0, 3'b000, 24'd0);
      check(done && !busy, "R7 zero count done", done, 1);
      repeat (4) @(negedge clk);
      check(!bus_ack_out && !bus_req_out && src_idx == s0, "R7 no handshake", src_idx - s0, 0);
    end

    // R8: one-cycle glitch on phase lines is ignored
    bus_phase_in = 3'b000;
    repeat (8) @(negedge clk);
    kick(1'b0, 3'b000, 24'd1);
    repeat (10) @(negedge clk);
    bus_phase_in = 3'b011;
    @(negedge clk);
    bus_phase_in = 3'b000;
    repeat (10) @(negedge clk);
    check(!irq && busy, "R8 glitch ignored", irq, 0);
    tgt_side_byte(1'b1, 8'hA0 + exp_src[7:0], 1'b0, 1'b0, 1'b0);
    exp_src++;
    repeat (3) @(negedge clk);
    check(done && !irq, "R8 transfer finishes", done, 1);

    // R9: phase change mid-transfer
    bus_phase_in = 3'b001;
    repeat (8) @(negedge clk);
    kick(1'b0, 3'b001, 24'd4);
    tgt_side_byte(1'b0, 8'h11, 1'b0, 1'b0, 1'b0);
    tgt_side_byte(1'b0, 8'h12, 1'b0, 1'b0, 1'b0);
    bus_phase_in = 3'b011;
    repeat (12) @(negedge clk);
    check(irq && irq_cause == 2'b01 && !busy && !done, "R9 mid-transfer mismatch",
          {irq, irq_cause}, 3'b101);
    check(remaining == 24'd2, "R9 remaining count", remaining, 2);

    // R11: start while busy ignored
    bus_phase_in = 3'b000;
    repeat (8) @(negedge clk);
    kick(1'b0, 3'b000, 24'd2);
    repeat (6) @(negedge clk);
    kick(1'b1, 3'b010, 24'd7);
    check(remaining == 24'd2 && !bus_phase_oe, "R11 busy start ignored", remaining, 2);
    for (int b = 0; b < 2; b++) begin
      tgt_side_byte(1'b1, 8'hA0 + exp_src[7:0], 1'b0, 1'b0, 1'b0);
      exp_src++;
    end
    repeat (4) @(negedge clk);
    check(done && remaining == 0 && !bus_phase_oe, "R11 original transfer completes", remaining, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule